// File: doc/BRIEF.md
# Comparison Response Analyser Scan Chain

This block collects the results of a self-test that runs the same pattern sequence on several identical RAMs at once. It holds an array of single-bit analyser cells. Each cell compares one data bit taken from two sources and keeps a mismatch flag. Once the flag is set, it stays set until reset, so a single wrong read at any point in the test is never lost. Sampling happens only on cycles where the pattern generator marks the read data valid.

The flags are the stages of a shift register. A single shift control moves the results out serially through one scan-out pin, and the block uses no other control than clock, reset, shift and scan-out. In the default ring mode, bit b of each port of RAM r is compared with the same port and bit of RAM r+1. The last RAM is compared with RAM 0, so every RAM takes part in two comparisons. This mode builds NUM_RAM x DATA_W x 2 cells. The compact mode compares port A with port B of the same RAM. It needs half the cells, but a failure can then only be traced to a whole RAM.

Top module: `ora_chain`

## Requirements
- R1: A synchronous active-high reset clears every flag, so scan_out is 0 in the cycle after reset and the whole chain reads out as zeros.
- R2: In ring mode (MODE=CMP_RING), the cell for RAM r, port p, bit b is set by a sampled cycle in which bit b of port p differs between RAM r and RAM r+1. Data bit b of RAM r sits at index r*DATA_W+b of port_a_data (p=0) or port_b_data (p=1).
- R3: In ring mode, RAM NUM_RAM-1 is compared with RAM 0. A fault on one bit of any single RAM therefore sets exactly two cells: its own cell and the cell of the RAM below it, taken modulo NUM_RAM.
- R4: A set flag stays set through any number of later matching samples until reset.
- R5: A mismatch has no effect unless cmp_valid is 1 and shift_en is 0 in that cycle.
- R6: When shift_en and cmp_valid are both 1, the chain shifts and no mismatch of that cycle is captured.
- R7: Each cycle with shift_en=1 moves every flag one cell toward scan_out and loads 0 into the cell farthest from the output. After as many shifts as there are cells, scan_out stays 0.
- R8: Cell k drives the next cell k-1, and cell 0 drives scan_out. In ring mode k=(r*2+p)*DATA_W+b, which gives RAM-major, then port, then bit order, starting with RAM 0 port A bit 0.
- R9: In the compact mode (MODE=CMP_INTRA), there are NUM_RAM*DATA_W cells. Cell r*DATA_W+b is set when bit b of port A differs from bit b of port B of RAM r, and it appears at scan position r*DATA_W+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high clear of all flags |
| shift_en | input | 1 | Shift the flag chain one position toward scan_out |
| cmp_valid | input | 1 | Read data is valid this cycle and is compared |
| port_a_data | input | NUM_RAM*DATA_W | Port A read data of all RAMs, RAM r at bits r*DATA_W upward |
| port_b_data | input | NUM_RAM*DATA_W | Port B read data of all RAMs, same layout |
| scan_out | output | 1 | Flag held in cell 0 |

## Verification
Shifting and sampling can both be requested in the same cycle. The bench raises shift_en and cmp_valid together while a fresh mismatch is on the data inputs. It then scans the whole chain and expects the old flags to have moved by one position and the new mismatch to be absent. Single-bit fault sweeps over every RAM, port and bit, followed by full scans, cover the ring neighbours, the wrap cell and the scan order in both modes.

// File: rtl/ora_pkg.sv
package ora_pkg;

    typedef enum logic {
        CMP_RING  = 1'b0,
        CMP_INTRA = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic shift;
        logic sample;
    } ora_ctl_t;

    function automatic int ports_per_ram(cmp_mode_e mode);
        return (mode == CMP_RING) ? 2 : 1;
    endfunction

    function automatic int num_cells(cmp_mode_e mode, int n_ram, int d_w);
        return n_ram * d_w * ports_per_ram(mode);
    endfunction

    function automatic int ring_next(int r, int n_ram);
        return (r + 1) % n_ram;
    endfunction

endpackage

// File: rtl/ora_ctl.sv
module ora_ctl
    import ora_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    input  logic     cmp_valid,
    output ora_ctl_t ctl
);
    always_comb begin
        ctl.shift  = shift_en;
        ctl.sample = cmp_valid & ~shift_en;
    end

    AST_SHIFT_WINS: assert property (@(posedge clk) disable iff (rst)
        (shift_en && cmp_valid) |-> (ctl.shift && !ctl.sample)); // R6
endmodule

// File: rtl/ora_compare.sv
module ora_compare
    import ora_pkg::*;
#(
    parameter int        NUM_RAM = 4,
    parameter int        DATA_W  = 8,
    parameter cmp_mode_e MODE    = CMP_RING,
    localparam int       BUS_W   = NUM_RAM * DATA_W,
    localparam int       CELLS   = num_cells(MODE, NUM_RAM, DATA_W)
)(
    input  logic [BUS_W-1:0] a_data,
    input  logic [BUS_W-1:0] b_data,
    output logic [CELLS-1:0] mismatch
);
    generate
        if (MODE == CMP_RING) begin : g_ring
            for (genvar r = 0; r < NUM_RAM; r++) begin : g_ram
                localparam int NR = ring_next(r, NUM_RAM);
                for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                    assign mismatch[(r*2+0)*DATA_W+b] =
                        a_data[r*DATA_W+b] ^ a_data[NR*DATA_W+b];
                    assign mismatch[(r*2+1)*DATA_W+b] =
                        b_data[r*DATA_W+b] ^ b_data[NR*DATA_W+b];
                end
            end
        end else begin : g_intra
            for (genvar r = 0; r < NUM_RAM; r++) begin : g_ram
                for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                    assign mismatch[r*DATA_W+b] =
                        a_data[r*DATA_W+b] ^ b_data[r*DATA_W+b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ora_cell.sv
module ora_cell
    import ora_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ora_ctl_t ctl,
    input  logic     mismatch,
    input  logic     shift_in,
    output logic     flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (ctl.shift)
            flag_q <= shift_in;
        else if (ctl.sample)
            flag_q <= flag_q | mismatch;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !flag_q); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ctl.shift) |=> flag_q); // R4
    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        ctl.shift |=> (flag_q == $past(shift_in))); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.shift && !ctl.sample) |=> $stable(flag_q)); // R5
endmodule

// File: rtl/ora_chain.sv
module ora_chain
    import ora_pkg::*;
#(
    parameter int        NUM_RAM = 4,
    parameter int        DATA_W  = 8,
    parameter cmp_mode_e MODE    = CMP_RING
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic                      cmp_valid,
    input  logic [NUM_RAM*DATA_W-1:0] port_a_data,
    input  logic [NUM_RAM*DATA_W-1:0] port_b_data,
    output logic                      scan_out
);
    localparam int CELLS = num_cells(MODE, NUM_RAM, DATA_W);

    ora_ctl_t         ctl;
    logic [CELLS-1:0] mismatch;
    logic [CELLS:0]   chain;

    ora_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .cmp_valid (cmp_valid),
        .ctl       (ctl)
    );

    ora_compare #(.NUM_RAM(NUM_RAM), .DATA_W(DATA_W), .MODE(MODE)) u_cmp (
        .a_data   (port_a_data),
        .b_data   (port_b_data),
        .mismatch (mismatch)
    );

    assign chain[CELLS] = 1'b0;

    generate
        for (genvar k = 0; k < CELLS; k++) begin : g_cell
            ora_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl),
                .mismatch (mismatch[k]),
                .shift_in (chain[k+1]),
                .flag_q   (chain[k])
            );
        end
    endgenerate

    assign scan_out = chain[0];

    AST_SCAN_CLEAR: assert property (@(posedge clk)
        rst |=> !scan_out); // R1
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (scan_out == $past(chain[1]))); // R8
endmodule

// File: tb/ora_chain_tb.sv
`timescale 1ns/1ps
module ora_chain_tb_top;
    import ora_pkg::*;

    localparam int N  = 3;
    localparam int D  = 4;
    localparam int CR = N * D * 2;
    localparam int CI = N * D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_en = 1'b0;
    logic cmp_valid = 1'b0;
    logic [N*D-1:0] a_d = '0;
    logic [N*D-1:0] b_d = '0;
    logic so_ring, so_intra;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [CR-1:0] exp_r = '0;
    logic [CI-1:0] exp_i = '0;

    always #2.5 clk = ~clk;

    ora_chain #(.NUM_RAM(N), .DATA_W(D), .MODE(CMP_RING)) dut_i (
        .clk(clk), .rst(rst), .shift_en(shift_en), .cmp_valid(cmp_valid),
        .port_a_data(a_d), .port_b_data(b_d), .scan_out(so_ring));

    ora_chain #(.NUM_RAM(N), .DATA_W(D), .MODE(CMP_INTRA)) dut_intra_i (
        .clk(clk), .rst(rst), .shift_en(shift_en), .cmp_valid(cmp_valid),
        .port_a_data(a_d), .port_b_data(b_d), .scan_out(so_intra));

    function automatic logic [CR-1:0] mm_ring();
        logic [CR-1:0] m = '0;
        for (int r = 0; r < N; r++) begin
            int nr = (r + 1) % N;
            for (int b = 0; b < D; b++) begin
                m[(r*2+0)*D+b] = a_d[r*D+b] ^ a_d[nr*D+b];
                m[(r*2+1)*D+b] = b_d[r*D+b] ^ b_d[nr*D+b];
            end
        end
        return m;
    endfunction

    // expected model, built from R1 R4 R5 R6 R7
    always @(posedge clk) begin
        if (rst) begin
            exp_r <= '0;
            exp_i <= '0;
        end else if (shift_en) begin
            exp_r <= exp_r >> 1;
            exp_i <= exp_i >> 1;
        end else if (cmp_valid) begin
            exp_r <= exp_r | mm_ring();
            exp_i <= exp_i | (a_d ^ b_d);
        end
    end

    task automatic chk(string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; shift_en = 1'b0; cmp_valid = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic set_clean(logic [D-1:0] w);
        for (int r = 0; r < N; r++) begin
            a_d[r*D +: D] = w;
            b_d[r*D +: D] = w;
        end
    endtask

    task automatic scan_all(string tag, bit do_ring, bit do_intra);
        cmp_valid = 1'b0;
        for (int i = 0; i < CR + 2; i++) begin
            if (do_ring)  chk(tag, so_ring,  exp_r[0]);
            if (do_intra) chk(tag, so_intra, exp_i[0]);
            shift_en = 1'b1;
            step();
        end
        shift_en = 1'b0;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 reset ring", so_ring, 1'b0);
        chk("R1 reset intra", so_intra, 1'b0);
        scan_all("R1 R7 cleared chain", 1, 1);

        // R2 R3 R8: single-bit fault sweep in ring mode
        for (int r = 0; r < N; r++)
            for (int p = 0; p < 2; p++)
                for (int b = 0; b < D; b++) begin
                    do_reset();
                    set_clean(4'b1010);
                    if (p == 0) a_d[r*D+b] = ~a_d[r*D+b];
                    else        b_d[r*D+b] = ~b_d[r*D+b];
                    cmp_valid = 1'b1;
                    step();
                    cmp_valid = 1'b0;
                    chk("R2 R3 ring own cell", exp_r[(r*2+p)*D+b], 1'b1);
                    chk("R3 ring wrap neighbour",
                        exp_r[(((r+N-1)%N)*2+p)*D+b], 1'b1);
                    chk("R3 two cells", 1'($countones(exp_r) == 2), 1'b1);
                    scan_all("R2 R3 R8 ring scan", 1, 0);
                end

        // R9: compact mode sweep, faults on port A then port B
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < CI; k++) begin
                do_reset();
                set_clean(4'b0110);
                if (p == 0) a_d[k] = ~a_d[k];
                else        b_d[k] = ~b_d[k];
                cmp_valid = 1'b1;
                step();
                chk("R9 intra cell", exp_i[k], 1'b1);
                scan_all("R9 intra scan", 0, 1);
            end

        // R4: sticky through later matching samples
        do_reset();
        set_clean(4'b1100);
        a_d[1*D+3] = ~a_d[1*D+3];
        b_d[0] = ~b_d[0];
        cmp_valid = 1'b1;
        step();
        set_clean(4'b1100);
        for (int i = 0; i < 5; i++) step();
        set_clean(4'b0011);
        step();
        chk("R4 sticky model", 1'(exp_r != '0), 1'b1);
        scan_all("R4 sticky scan", 1, 1);

        // R5: mismatch without valid is ignored
        do_reset();
        set_clean(4'b1111);
        a_d = ~a_d;
        b_d[5] = 1'b0;
        for (int i = 0; i < 4; i++) step();
        chk("R5 ignored ring", so_ring, 1'b0);
        chk("R5 ignored intra", so_intra, 1'b0);
        scan_all("R5 no capture", 1, 1);

        // R6: shift and valid in the same cycle
        do_reset();
        set_clean(4'b0101);
        a_d[0] = ~a_d[0];
        b_d[2*D+1] = ~b_d[2*D+1];
        cmp_valid = 1'b1;
        step();
        set_clean(4'b0101);
        b_d[1*D+2] = ~b_d[1*D+2];
        a_d[3] = ~a_d[3];
        shift_en = 1'b1;
        cmp_valid = 1'b1;
        step();
        shift_en = 1'b0;
        cmp_valid = 1'b0;
        set_clean(4'b0101);
        chk("R6 old flag moved ring", so_ring, 1'b0);
        chk("R6 new mismatch dropped ring", exp_r[(1*2+1)*D+2], 1'b0);
        scan_all("R6 R7 shift wins", 1, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule